// File: doc/BRIEF.md
# XAUI Receive Fault Ordered-Set Generator

This block sits on the receive side of a four-lane XAUI path, just after lane deskew and 8b/10b decoding. Each clock it takes one received column (one byte and one control flag per lane) together with lane-health flags: per-lane signal presence, per-lane comma lock and a single "all lanes deskewed" flag. From these it decides whether the link is locally faulted. It then drives one registered XGMII-side column.

The block only acts when the XAUI enable input is high. While any health condition fails, it discards the received data and emits the local fault sequence ordered set on every column. When the lanes are healthy, a received local or remote fault sequence is forwarded as the matching ordered set. Any other column is passed through unchanged. With the enable low, every column is passed through untouched and no fault is reported.

A fault sequence column has the sequence character 0x9C with its control flag set on lane 0. Lanes 1 and 2 carry data 0x00. Lane 3 carries data 0x01 for local fault or 0x02 for remote fault. The control flags of lanes 1 to 3 are clear. Lane n occupies bits [8n+7:8n] of the data buses and bit n of the control buses.

Top module: `xaui_rx_fault_gen`

## Requirements
- R1: While reset is asserted, every output is zero on the following clock edge: data, control, error flag, local-fault flag, and fault status 0 (none).
- R2: With the XAUI enable low, each output column equals the input column of the previous cycle. Fault status is 0, and the local-fault and error flags are 0, whatever the health inputs show.
- R3: With the enable high and the signal-present flag of any one lane low, the next output column is the local fault set: data 0x0100009C, control 4'b0001.
- R4: With the enable high and the comma-lock flag of any lane low, the next output column is the local fault set.
- R5: With the enable high and the deskew-complete flag low, the next output column is the local fault set.
- R6: While a local fault is declared, the local-fault flag is 1, the error flag is 1 and the fault status is 1 (local).
- R7: The local-fault flag clears on the edge that follows the first cycle in which the enable is high and all three health conditions are met.
- R8: With the enable high and healthy lanes, a received remote fault column (data 0x0200009C, control 4'b0001) is output one cycle later unchanged, with status 2 (remote) and the error and local-fault flags at 0.
- R9: With the enable high and healthy lanes, a received local fault column is output one cycle later as the local fault set, with status 1, the local-fault flag at 0 and the error flag at 0.
- R10: With the enable high and healthy lanes, any other column is passed through one cycle later with status 0. This includes columns that differ from a fault set only in one byte or one control flag.
- R11: A locally declared fault takes precedence: an unhealthy link with a received remote fault column still yields the local fault set and status 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive column clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xaui_en | input | 1 | Enables fault detection and fault-set handling |
| sig_det | input | 4 | Per-lane signal present flag |
| comma_det | input | 4 | Per-lane comma lock flag |
| deskew_done | input | 1 | All lanes deskewed |
| rx_data | input | 32 | Received column bytes, lane n in bits [8n+7:8n] |
| rx_ctrl | input | 4 | Received column control flags, lane n in bit n |
| xgmii_data | output | 32 | Output column bytes |
| xgmii_ctrl | output | 4 | Output column control flags |
| col_err | output | 1 | Output column replaced because of a local fault |
| local_fault | output | 1 | Registered local fault declaration |
| fault_state | output | 2 | Fault status: 0 none, 1 local, 2 remote |

## Verification
The bench builds the block with its default four lanes and eight-bit bytes. These are the only values for which the fault set is defined. With them, every lane index can be dropped individually, from either the signal-present or the comma-lock side, and lane 3 serves as the code-carrying lane. A behavioural model predicts each column one cycle ahead and is compared against the design on every clock. Directed columns reach near-miss sequence patterns, fault-to-healthy recovery, and the precedence of a local fault over a received remote fault. Random phases then mix enable, health and data.

// File: rtl/xrf_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the receive fault ordered-set generator.
// Assumes byte-wide lanes; the sequence character and codes are 8-bit values.
package xrf_pkg;
    localparam int XRF_LANES  = 4;
    localparam int XRF_BYTE_W = 8;

    localparam logic [7:0] SEQ_CHAR = 8'h9C;  // K28.4 sequence character
    localparam logic [7:0] LF_CODE  = 8'h01;  // D1.0, local fault code
    localparam logic [7:0] RF_CODE  = 8'h02;  // D2.0, remote fault code

    typedef enum logic [1:0] {
        FAULT_NONE   = 2'd0,
        FAULT_LOCAL  = 2'd1,
        FAULT_REMOTE = 2'd2
    } fault_kind_e;
endpackage

// File: rtl/xrf_lane_health.sv
`timescale 1ns/1ps
// Lane health evaluation.
// Combines per-lane signal presence and comma lock with the shared deskew
// flag into a single link-good indication. Purely combinational; the caller
// registers the result.
module xrf_lane_health #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] sig_det,
    input  logic [LANES-1:0] comma_det,
    input  logic             deskew_done,
    output logic             link_ok
);
    logic [LANES-1:0] lane_ok;

    // Per-lane health: a lane is good only with signal and comma lock.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] = sig_det[g] & comma_det[g];
    end

    // Link is good when every lane is good and the lanes are aligned.
    assign link_ok = (&lane_ok) & deskew_done;
endmodule

// File: rtl/xrf_seq_detect.sv
`timescale 1ns/1ps
// Received fault sequence detector.
// Recognises a column holding the local or remote fault ordered set.
// Assumes lane 0 carries the sequence character and the last lane the code.
module xrf_seq_detect #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0] col_data,
    input  logic [LANES-1:0]        col_ctrl,
    output logic                    is_lf,
    output logic                    is_rf
);
    import xrf_pkg::*;

    logic [LANES-1:0] hit_lf;
    logic [LANES-1:0] hit_rf;

    // Per-lane match against the expected byte and control flag of each set.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] b;
        assign b = col_data[g*BYTE_W +: BYTE_W];
        if (g == 0) begin : g_head
            assign hit_lf[g] = col_ctrl[g] && (b == BYTE_W'(SEQ_CHAR));
            assign hit_rf[g] = hit_lf[g];
        end else if (g == LANES - 1) begin : g_tail
            assign hit_lf[g] = !col_ctrl[g] && (b == BYTE_W'(LF_CODE));
            assign hit_rf[g] = !col_ctrl[g] && (b == BYTE_W'(RF_CODE));
        end else begin : g_mid
            assign hit_lf[g] = !col_ctrl[g] && (b == '0);
            assign hit_rf[g] = hit_lf[g];
        end
    end

    // A set is recognised only when every lane matches.
    assign is_lf = &hit_lf;
    assign is_rf = &hit_rf;
endmodule

// File: rtl/xrf_col_builder.sv
`timescale 1ns/1ps
// Fault ordered-set column builder.
// Produces the local or remote fault column: the sequence character with
// control set on lane 0, zero data bytes on the middle lanes, and the code
// byte on the last lane.
module xrf_col_builder #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    remote,
    output logic [LANES*BYTE_W-1:0] set_data,
    output logic [LANES-1:0]        set_ctrl
);
    import xrf_pkg::*;

    // Per-lane constant selection; only the last lane depends on the kind.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_head
            assign set_data[g*BYTE_W +: BYTE_W] = BYTE_W'(SEQ_CHAR);
            assign set_ctrl[g]                  = 1'b1;
        end else if (g == LANES - 1) begin : g_tail
            assign set_data[g*BYTE_W +: BYTE_W] = remote ? BYTE_W'(RF_CODE)
                                                         : BYTE_W'(LF_CODE);
            assign set_ctrl[g]                  = 1'b0;
        end else begin : g_mid
            assign set_data[g*BYTE_W +: BYTE_W] = '0;
            assign set_ctrl[g]                  = 1'b0;
        end
    end
endmodule

// File: rtl/xaui_rx_fault_gen.sv
`timescale 1ns/1ps
// XAUI receive fault ordered-set generator (top).
// Declares a local fault from lane health when enabled. It replaces output
// columns with the local fault set, forwards received fault sets, and
// otherwise passes columns through. All outputs are registered, one cycle
// after the inputs. Assumes LANES >= 2 and BYTE_W >= 8.
module xaui_rx_fault_gen #(
    parameter int LANES  = xrf_pkg::XRF_LANES,
    parameter int BYTE_W = xrf_pkg::XRF_BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xaui_en,
    input  logic [LANES-1:0]        sig_det,
    input  logic [LANES-1:0]        comma_det,
    input  logic                    deskew_done,
    input  logic [LANES*BYTE_W-1:0] rx_data,
    input  logic [LANES-1:0]        rx_ctrl,
    output logic [LANES*BYTE_W-1:0] xgmii_data,
    output logic [LANES-1:0]        xgmii_ctrl,
    output logic                    col_err,
    output logic                    local_fault,
    output logic [1:0]              fault_state
);
    import xrf_pkg::*;

    localparam int COL_W = LANES * BYTE_W;

    logic             link_ok;
    logic             rx_is_lf;
    logic             rx_is_rf;
    logic             declare_lf;
    logic             build_remote;
    logic [COL_W-1:0] set_data;
    logic [LANES-1:0] set_ctrl;

    logic [COL_W-1:0] nxt_data;
    logic [LANES-1:0] nxt_ctrl;
    logic             nxt_err;
    logic             nxt_lf;
    fault_kind_e      nxt_kind;
    fault_kind_e      kind_q;

    xrf_lane_health #(.LANES(LANES)) health_i (
        .sig_det     (sig_det),
        .comma_det   (comma_det),
        .deskew_done (deskew_done),
        .link_ok     (link_ok)
    );

    xrf_seq_detect #(.LANES(LANES), .BYTE_W(BYTE_W)) detect_i (
        .col_data (rx_data),
        .col_ctrl (rx_ctrl),
        .is_lf    (rx_is_lf),
        .is_rf    (rx_is_rf)
    );

    xrf_col_builder #(.LANES(LANES), .BYTE_W(BYTE_W)) build_i (
        .remote   (build_remote),
        .set_data (set_data),
        .set_ctrl (set_ctrl)
    );

    // Local fault exists only when enabled and the link is unhealthy.
    assign declare_lf   = xaui_en && !link_ok;
    // Build the remote set only for a forwarded remote column.
    assign build_remote = !declare_lf && rx_is_rf;

    // Next-column selection in priority order: disabled, local, remote, local rx, pass.
    always_comb begin
        nxt_data = rx_data;
        nxt_ctrl = rx_ctrl;
        nxt_err  = 1'b0;
        nxt_lf   = 1'b0;
        nxt_kind = FAULT_NONE;
        if (xaui_en) begin
            if (declare_lf) begin
                nxt_data = set_data;
                nxt_ctrl = set_ctrl;
                nxt_err  = 1'b1;
                nxt_lf   = 1'b1;
                nxt_kind = FAULT_LOCAL;
            end else if (rx_is_rf) begin
                nxt_data = set_data;
                nxt_ctrl = set_ctrl;
                nxt_kind = FAULT_REMOTE;
            end else if (rx_is_lf) begin
                nxt_data = set_data;
                nxt_ctrl = set_ctrl;
                nxt_kind = FAULT_LOCAL;
            end
        end
    end

    // Output column register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xgmii_data  <= '0;
            xgmii_ctrl  <= '0;
            col_err     <= 1'b0;
            local_fault <= 1'b0;
            kind_q      <= FAULT_NONE;
        end else begin
            xgmii_data  <= nxt_data;
            xgmii_ctrl  <= nxt_ctrl;
            col_err     <= nxt_err;
            local_fault <= nxt_lf;
            kind_q      <= nxt_kind;
        end
    end

    // Status output as a plain vector.
    assign fault_state = kind_q;
endmodule

// File: rtl/xrf_fault_chk.sv
`timescale 1ns/1ps
// Assertion checker for xaui_rx_fault_gen, attached with bind.
// Relates the health and column inputs to the registered outputs one cycle later.
module xrf_fault_chk #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    xaui_en,
    input logic [LANES-1:0]        sig_det,
    input logic [LANES-1:0]        comma_det,
    input logic                    deskew_done,
    input logic [LANES*BYTE_W-1:0] rx_data,
    input logic [LANES-1:0]        rx_ctrl,
    input logic [LANES*BYTE_W-1:0] xgmii_data,
    input logic [LANES-1:0]        xgmii_ctrl,
    input logic                    col_err,
    input logic                    local_fault,
    input logic [1:0]              fault_state
);
    function automatic logic [LANES*BYTE_W-1:0] seq_col(input logic [7:0] code);
        logic [LANES*BYTE_W-1:0] c;
        c = '0;
        c[BYTE_W-1:0] = BYTE_W'(8'h9C);
        c[(LANES-1)*BYTE_W +: BYTE_W] = BYTE_W'(code);
        return c;
    endfunction

    localparam logic [LANES*BYTE_W-1:0] LF_COL  = seq_col(8'h01);
    localparam logic [LANES*BYTE_W-1:0] RF_COL  = seq_col(8'h02);
    localparam logic [LANES-1:0]        SEQ_CTL = LANES'(1);

    logic healthy;
    assign healthy = (&sig_det) && (&comma_det) && deskew_done;

    // R3
    sigdet_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xaui_en && !(&sig_det)) |=> (local_fault && xgmii_data == LF_COL && xgmii_ctrl == SEQ_CTL));

    // R4
    comma_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xaui_en && !(&comma_det)) |=> (local_fault && xgmii_data == LF_COL && xgmii_ctrl == SEQ_CTL));

    // R5
    deskew_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xaui_en && !deskew_done) |=> (local_fault && xgmii_data == LF_COL && xgmii_ctrl == SEQ_CTL));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xaui_en |=> (xgmii_data == $past(rx_data) && xgmii_ctrl == $past(rx_ctrl)
                      && fault_state == 2'd0 && !local_fault && !col_err));

    // R6
    lf_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        local_fault |-> (fault_state == 2'd1 && col_err));

    // R7
    lf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xaui_en && healthy) |=> !local_fault);

    // R8
    rf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xaui_en && healthy && rx_data == RF_COL && rx_ctrl == SEQ_CTL)
        |=> (fault_state == 2'd2 && xgmii_data == RF_COL && !col_err));
endmodule

bind xaui_rx_fault_gen xrf_fault_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .xaui_en     (xaui_en),
    .sig_det     (sig_det),
    .comma_det   (comma_det),
    .deskew_done (deskew_done),
    .rx_data     (rx_data),
    .rx_ctrl     (rx_ctrl),
    .xgmii_data  (xgmii_data),
    .xgmii_ctrl  (xgmii_ctrl),
    .col_err     (col_err),
    .local_fault (local_fault),
    .fault_state (fault_state)
);

// File: tb/xaui_rx_fault_gen_tb_top.sv
`timescale 1ns/1ps
// Bench for xaui_rx_fault_gen: behavioural per-cycle reference model.
module xaui_rx_fault_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xaui_en = 1'b0;
    logic [3:0]  sig_det = 4'hF;
    logic [3:0]  comma_det = 4'hF;
    logic        deskew_done = 1'b1;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_ctrl = '0;
    logic [31:0] xgmii_data;
    logic [3:0]  xgmii_ctrl;
    logic        col_err;
    logic        local_fault;
    logic [1:0]  fault_state;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [31:0] LF_W = 32'h0100009C;
    localparam logic [31:0] RF_W = 32'h0200009C;

    always #5 clk = ~clk;

    xaui_rx_fault_gen dut_i (
        .clk(clk), .rst_n(rst_n), .xaui_en(xaui_en), .sig_det(sig_det),
        .comma_det(comma_det), .deskew_done(deskew_done), .rx_data(rx_data),
        .rx_ctrl(rx_ctrl), .xgmii_data(xgmii_data), .xgmii_ctrl(xgmii_ctrl),
        .col_err(col_err), .local_fault(local_fault), .fault_state(fault_state)
    );

    // Compute the expected outputs from the inputs now applied, compare after the edge.
    task automatic tick(input string req);
        logic [31:0] e_d; logic [3:0] e_c; logic e_err, e_lf; int e_st;
        bit ok;
        ok = (sig_det == 4'hF) && (comma_det == 4'hF) && (deskew_done == 1'b1);
        e_d = rx_data; e_c = rx_ctrl; e_err = 0; e_lf = 0; e_st = 0;
        if (!rst_n) begin
            e_d = 0; e_c = 0;
        end else if (xaui_en) begin
            if (!ok) begin
                e_d = LF_W; e_c = 4'b0001; e_err = 1; e_lf = 1; e_st = 1;
            end else if (rx_data == RF_W && rx_ctrl == 4'b0001) begin
                e_st = 2;
            end else if (rx_data == LF_W && rx_ctrl == 4'b0001) begin
                e_st = 1;
            end
        end
        @(posedge clk);
        #2;
        n_cmp++;
        if (xgmii_data !== e_d || xgmii_ctrl !== e_c || col_err !== e_err ||
            local_fault !== e_lf || fault_state !== 2'(e_st)) begin
            n_bad++;
            $display("FAIL %s: got d=%h c=%b err=%b lf=%b st=%0d exp d=%h c=%b err=%b lf=%b st=%0d",
                     req, xgmii_data, xgmii_ctrl, col_err, local_fault, fault_state,
                     e_d, e_c, e_err, e_lf, e_st);
        end
    endtask

    task automatic healthy();
        sig_det = 4'hF; comma_det = 4'hF; deskew_done = 1'b1;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, with unhealthy enabled inputs present
        rst_n = 0; xaui_en = 1; sig_det = 4'h0; rx_data = 32'hDEADBEEF; rx_ctrl = 4'hF;
        for (int i = 0; i < 3; i++) tick("R1");
        #1; rst_n = 1; healthy();

        // R2: disabled, unhealthy lanes and fault columns pass untouched
        xaui_en = 0;
        for (int i = 0; i < 12; i++) begin
            sig_det = 4'($urandom); comma_det = 4'($urandom); deskew_done = 1'($urandom);
            rx_data = (i % 3 == 0) ? RF_W : $urandom; rx_ctrl = (i % 3 == 0) ? 4'b0001 : 4'($urandom);
            tick("R2");
        end

        // R10: enabled, healthy, ordinary columns
        xaui_en = 1; healthy();
        for (int i = 0; i < 10; i++) begin
            rx_data = $urandom; rx_ctrl = 4'($urandom); tick("R10");
        end

        // R3 / R6 / R7: drop signal on each lane, then recover
        for (int l = 0; l < 4; l++) begin
            rx_data = $urandom; sig_det = 4'hF & ~(4'b1 << l); tick("R3");
            tick("R6");
            healthy(); tick("R7");
        end
        // R4: drop comma lock on each lane
        for (int l = 0; l < 4; l++) begin
            rx_data = $urandom; comma_det = 4'hF & ~(4'b1 << l); tick("R4");
            healthy(); tick("R7");
        end
        // R5: deskew lost
        deskew_done = 0; rx_data = $urandom; tick("R5"); tick("R5");
        healthy(); tick("R7");

        // R8: received remote fault
        rx_data = RF_W; rx_ctrl = 4'b0001; tick("R8"); tick("R8");
        // R9: received local fault
        rx_data = LF_W; rx_ctrl = 4'b0001; tick("R9");
        // R10: near misses
        rx_data = RF_W; rx_ctrl = 4'b0011; tick("R10");
        rx_data = RF_W; rx_ctrl = 4'b0000; tick("R10");
        rx_data = 32'h0300009C; rx_ctrl = 4'b0001; tick("R10");
        rx_data = 32'h0201009C; rx_ctrl = 4'b0001; tick("R10");
        rx_data = 32'h0200009D; rx_ctrl = 4'b0001; tick("R10");
        rx_data = RF_W; rx_ctrl = 4'b1001; tick("R10");

        // R11: local declaration beats received remote fault
        rx_data = RF_W; rx_ctrl = 4'b0001; comma_det = 4'b1011; tick("R11");
        healthy(); tick("R8");

        // Mixed random phase across all behaviours
        for (int i = 0; i < 400; i++) begin
            xaui_en = ($urandom % 8) != 0;
            sig_det = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
            comma_det = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
            deskew_done = ($urandom % 8) != 0;
            case ($urandom % 4)
                0: begin rx_data = RF_W; rx_ctrl = 4'b0001; end
                1: begin rx_data = LF_W; rx_ctrl = 4'b0001; end
                default: begin rx_data = $urandom; rx_ctrl = 4'($urandom); end
            endcase
            tick("R10");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule